// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a first-level data cache placed between a single requester that reads and writes 32-bit words and a slower backing store that moves whole four-word lines. Each line slot keeps a tag, a valid bit and a dirty bit. Hits complete in the cycle they are presented. A miss is resolved in separate phases while the requester is held with a wait indication. If the resident line has been modified, it is first copied out to the backing store. The wanted line is then fetched. Only after that does the access complete.

The requester presents a 16-bit two's-complement word address, and this address is reduced modulo the 1024-word memory space. It holds address, write flag and write data stable for as long as it sees the wait indication. The backing store handshake is request/acknowledge. The cache keeps the request, address, write flag and line data steady until a one-cycle acknowledge arrives, and read data are taken in the acknowledge cycle.

Top module: `dm_wb_cache`

## Requirements
- R1: The request address is wrapped modulo 1024 words by keeping its low 10 bits, so address 1024+a reaches the same word as a, and -10 (16'hFFF6) reaches word 1014.
- R2: The 10-bit word address splits as tag = bits [9:7], slot index = bits [6:2] and word-in-line = bits [1:0]. Word k of a line travels on line-bus bits [32k+31:32k]. `memAddr` is the word address of the line base, with bits [1:0] = 00.
- R3: A read that hits raises `respOk` with the addressed word on `respRdata` in the same cycle, and starts no backing access.
- R4: A write that hits updates only the addressed word in place and marks the line dirty, without any backing access.
- R5: A request that misses sees `respWait` high and `respOk` low until the miss is resolved. `respOk` and `respWait` are never high together.
- R6: On a miss whose resident line is valid and dirty, the whole line is first written to `{storedTag, index, 2'b00}`. Its dirty bit is cleared on that write's acknowledge, and only then does the line fill begin.
- R7: On a miss whose resident line is clean or invalid, no write-back occurs. Exactly one line read is made at the requested line base, after which the slot holds the new tag as valid and clean, and the access completes.
- R8: While `memReq` is high it stays high with `memAddr` and `memWe` unchanged until `memAck` is seen.
- R9: Reset leaves every slot invalid and clean and the controller idle, so the first access to any address afterwards misses and writes nothing back.
- R10: A write that misses first brings the line in as in R6/R7 and then merges the word, leaving the line dirty with the other three words from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requester presents an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Two's-complement word address, wrapped to 10 bits |
| reqWdata | input | 32 | Write data |
| respOk | output | 1 | Access completes this cycle |
| respWait | output | 1 | Access is held; retry next cycle |
| respRdata | output | 32 | Read data, valid with respOk |
| memReq | output | 1 | Backing access request |
| memWe | output | 1 | 1 = line write-back, 0 = line fetch |
| memAddr | output | 10 | Word address of the line base |
| memWline | output | 128 | Line written back |
| memAck | input | 1 | One-cycle completion of a backing access |
| memRline | input | 128 | Fetched line, valid with memAck |

## Verification
On every cycle the assertions check that ok and wait are exclusive, that a hit never starts a backing access, and that a write-back only happens for a dirty resident line and is followed at once by a fill. They also check that backing requests stay steady until acknowledged and that a fill acknowledge leads to completion on the next cycle. The directed scenarios show what needs data values: address wrapping and field split, in-place word merge, the contents and address of an evicted line, the absence of write-back for clean victims, and the loss of all cached state through reset.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic fillLine;    // load fetched line, set tag and valid, clear dirty
    logic clearDirty;  // write-back acknowledged
    logic writeWord;   // merge requester word, set dirty
    logic selVictim;   // address backing store from the stored tag
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int IN_ADDR_W  = 16,
  parameter int MEM_ADDR_W = 10,
  parameter int OFF_W      = 2,
  parameter int IDX_W      = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [IN_ADDR_W-1:0]              reqAddr,
  input  logic [WORD_W-1:0]                 reqWdata,
  input  dpCtrl_t                           dpCtrl,
  input  logic [(WORD_W<<OFF_W)-1:0]        memRline,
  output logic                              hit,
  output logic                              victimDirty,
  output logic [WORD_W-1:0]                 rdWord,
  output logic [MEM_ADDR_W-1:0]             memAddr,
  output logic [(WORD_W<<OFF_W)-1:0]        memWline
);

  localparam int TAG_W  = MEM_ADDR_W - IDX_W - OFF_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = WORD_W << OFF_W;

  logic [MEM_ADDR_W-1:0] wrapAddr;
  logic [TAG_W-1:0]      reqTag;
  logic [IDX_W-1:0]      reqIdx;
  logic [OFF_W-1:0]      reqOff;

  logic [LINE_W-1:0] dataArr [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validVec;
  logic [LINES-1:0]  dirtyVec;

  logic [LINE_W-1:0] curLine;
  logic [TAG_W-1:0]  curTag;

  // Two's-complement wrap modulo the power-of-two memory size
  assign wrapAddr = MEM_ADDR_W'(reqAddr);
  assign reqTag   = wrapAddr[MEM_ADDR_W-1 -: TAG_W];
  assign reqIdx   = wrapAddr[OFF_W +: IDX_W];
  assign reqOff   = wrapAddr[OFF_W-1:0];

  assign curLine = dataArr[reqIdx];
  assign curTag  = tagArr[reqIdx];

  assign hit         = validVec[reqIdx] && (curTag == reqTag);
  assign victimDirty = validVec[reqIdx] && dirtyVec[reqIdx];
  assign rdWord      = curLine[reqOff*WORD_W +: WORD_W];
  assign memWline    = curLine;
  assign memAddr     = dpCtrl.selVictim ? {curTag, reqIdx, {OFF_W{1'b0}}}
                                        : {reqTag, reqIdx, {OFF_W{1'b0}}};

  // Tag and state bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      dirtyVec <= '0;
    end else begin
      if (dpCtrl.fillLine) begin
        validVec[reqIdx] <= 1'b1;
        dirtyVec[reqIdx] <= 1'b0;
      end else if (dpCtrl.clearDirty) begin
        dirtyVec[reqIdx] <= 1'b0;
      end else if (dpCtrl.writeWord) begin
        dirtyVec[reqIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dpCtrl.fillLine) tagArr[reqIdx] <= reqTag;
  end

  // Line storage, no reset needed: guarded by validVec
  always_ff @(posedge clk) begin
    if (dpCtrl.fillLine)
      dataArr[reqIdx] <= memRline;
    else if (dpCtrl.writeWord)
      dataArr[reqIdx][reqOff*WORD_W +: WORD_W] <= reqWdata;
  end

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    hit,
  input  logic    victimDirty,
  input  logic    memAck,
  output logic    respOk,
  output logic    respWait,
  output logic    memReq,
  output logic    memWe,
  output dpCtrl_t dpCtrl
);

  ctrlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    respOk    = 1'b0;
    respWait  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    dpCtrl    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (hit) begin
            respOk           = 1'b1;
            dpCtrl.writeWord = reqWrite;
          end else begin
            respWait  = 1'b1;
            stateNext = victimDirty ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        respWait         = reqValid;
        memReq           = 1'b1;
        memWe            = 1'b1;
        dpCtrl.selVictim = 1'b1;
        if (memAck) begin
          dpCtrl.clearDirty = 1'b1;
          stateNext         = ST_FILL;
        end
      end
      ST_FILL: begin
        respWait = reqValid;
        memReq   = 1'b1;
        if (memAck) begin
          dpCtrl.fillLine = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int IN_ADDR_W  = 16,
  parameter int MEM_ADDR_W = 10,
  parameter int OFF_W      = 2,
  parameter int IDX_W      = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [IN_ADDR_W-1:0]       reqAddr,
  input  logic [WORD_W-1:0]          reqWdata,
  output logic                       respOk,
  output logic                       respWait,
  output logic [WORD_W-1:0]          respRdata,
  output logic                       memReq,
  output logic                       memWe,
  output logic [MEM_ADDR_W-1:0]      memAddr,
  output logic [(WORD_W<<OFF_W)-1:0] memWline,
  input  logic                       memAck,
  input  logic [(WORD_W<<OFF_W)-1:0] memRline
);

  dpCtrl_t dpCtrl;
  logic    hit;
  logic    victimDirty;

  dmc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .hit        (hit),
    .victimDirty(victimDirty),
    .memAck     (memAck),
    .respOk     (respOk),
    .respWait   (respWait),
    .memReq     (memReq),
    .memWe      (memWe),
    .dpCtrl     (dpCtrl)
  );

  dmc_datapath #(
    .WORD_W    (WORD_W),
    .IN_ADDR_W (IN_ADDR_W),
    .MEM_ADDR_W(MEM_ADDR_W),
    .OFF_W     (OFF_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .dpCtrl     (dpCtrl),
    .memRline   (memRline),
    .hit        (hit),
    .victimDirty(victimDirty),
    .rdWord     (respRdata),
    .memAddr    (memAddr),
    .memWline   (memWline)
  );

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int MEM_ADDR_W = 10
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  respOk,
  input logic                  respWait,
  input logic                  memReq,
  input logic                  memWe,
  input logic                  memAck,
  input logic [MEM_ADDR_W-1:0] memAddr,
  input logic                  victimDirty
);

  // R5
  a_r5_ok_wait_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(respOk && respWait));

  // R3
  a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    respOk |-> !memReq);

  // R6
  a_r6_evict_only_dirty: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> victimDirty);

  // R6
  a_r6_fill_follows_evict: assert property (@(posedge clk) disable iff (!rstN)
    (memAck && memReq && memWe) |=> (memReq && !memWe));

  // R8
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R7
  a_r7_fill_completes: assert property (@(posedge clk) disable iff (!rstN)
    (memAck && memReq && !memWe && reqValid) |=> respOk);

endmodule

bind dm_wb_cache dmc_checker #(.MEM_ADDR_W(MEM_ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .respOk     (respOk),
  .respWait   (respWait),
  .memReq     (memReq),
  .memWe      (memWe),
  .memAck     (memAck),
  .memAddr    (memAddr),
  .victimDirty(victimDirty)
);

// File: tb/dm_wb_cache_tb.sv
`timescale 1ns/1ps
module dm_wb_cache_tb;

  localparam int MEM_LAT = 3;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid, reqWrite;
  logic [15:0]  reqAddr;
  logic [31:0]  reqWdata;
  logic         respOk, respWait;
  logic [31:0]  respRdata;
  logic         memReq, memWe, memAck;
  logic [9:0]   memAddr;
  logic [127:0] memWline, memRline;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dm_wb_cache u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .respOk(respOk),
    .respWait(respWait), .respRdata(respRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWline(memWline),
    .memAck(memAck), .memRline(memRline)
  );

  // Backing store model: fixed latency, one-cycle ack
  logic [127:0] mem [256];
  logic         seeded = 1'b0;
  int           cnt = 0;
  int           memReads = 0, memWrites = 0;
  logic [9:0]   lastRdAddr = '0, lastWrAddr = '0;
  int           cycle = 0, lastRdCyc = 0, lastWrCyc = 0;

  always_ff @(posedge clk) begin
    cycle <= cycle + 1;
    if (!seeded) begin
      for (int l = 0; l < 256; l++)
        for (int w = 0; w < 4; w++)
          mem[l][w*32 +: 32] <= 32'hA000_0000 | 32'(l*4 + w);
      seeded <= 1'b1;
    end
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      if (cnt == MEM_LAT - 1) begin
        cnt    <= 0;
        memAck <= 1'b1;
        if (memWe) begin
          mem[memAddr[9:2]] <= memWline;
          memWrites  <= memWrites + 1;
          lastWrAddr <= memAddr;
          lastWrCyc  <= cycle;
        end else begin
          memRline   <= mem[memAddr[9:2]];
          memReads   <= memReads + 1;
          lastRdAddr <= memAddr;
          lastRdCyc  <= cycle;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  function automatic logic [31:0] pat(input int a);
    return 32'hA000_0000 | 32'(a);
  endfunction

  task automatic check(input logic cond, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a,
                        input logic [31:0] d, output logic [31:0] rd,
                        output int waits);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    waits = 0;
    #1;
    while (!respOk) begin
      if (respWait) waits++;
      @(negedge clk);
      #1;
    end
    rd = respRdata;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] rd; int w; int wr0;
    #1;
    check(!respOk && !respWait && !memReq, "R9 idle after reset",
          {29'b0, respOk, respWait, memReq}, 32'h0);
    wr0 = memWrites;
    access(1'b0, 16'h0055, '0, rd, w);
    check(w > 0, "R9 first access misses", 32'(w), 32'h1);
    check(memWrites == wr0, "R9 no write-back after reset", 32'(memWrites), 32'(wr0));
    check(rd == pat(16'h55), "R7 read miss data", rd, pat(16'h55));
    check(memReads == 1 && lastRdAddr == 10'h054, "R2 fill at line base 0x54",
          32'(lastRdAddr), 32'h54);
  endtask

  task automatic t_hits();
    logic [31:0] rd; int w; int rd0;
    rd0 = memReads;
    access(1'b0, 16'h0056, '0, rd, w);
    check(w == 0 && rd == pat(16'h56), "R3 read hit same cycle", rd, pat(16'h56));
    access(1'b1, 16'h0055, 32'hDEAD_0001, rd, w);
    check(w == 0, "R4 write hit no wait", 32'(w), 32'h0);
    access(1'b0, 16'h0055, '0, rd, w);
    check(rd == 32'hDEAD_0001, "R4 write hit updated word", rd, 32'hDEAD_0001);
    access(1'b0, 16'h0054, '0, rd, w);
    check(rd == pat(16'h54), "R4 neighbour word untouched", rd, pat(16'h54));
    check(memReads == rd0 && memWrites == 0, "R3 R4 hits make no backing access",
          32'(memReads), 32'(rd0));
  endtask

  task automatic t_wrap();
    logic [31:0] rd; int w;
    access(1'b0, 16'h0455, '0, rd, w);
    check(w == 0 && rd == 32'hDEAD_0001, "R1 1024+0x55 aliases 0x55", rd, 32'hDEAD_0001);
    access(1'b0, 16'hFFF6, '0, rd, w);
    check(rd == pat(1014), "R1 -10 reaches word 1014", rd, pat(1014));
    check(lastRdAddr == 10'h3F4, "R2 tag 7 idx 29 line base", 32'(lastRdAddr), 32'h3F4);
  endtask

  task automatic t_dirtyEvict();
    logic [31:0] rd; int w; logic [127:0] ln;
    access(1'b0, 16'h00D5, '0, rd, w);
    check(memWrites == 1, "R6 one write-back", 32'(memWrites), 32'h1);
    check(lastWrAddr == 10'h054, "R6 write-back address from stored tag",
          32'(lastWrAddr), 32'h54);
    ln = mem[8'h15];
    check(ln[63:32] == 32'hDEAD_0001, "R6 victim line contents", ln[63:32], 32'hDEAD_0001);
    check(lastWrCyc < lastRdCyc, "R6 write-back precedes fill",
          32'(lastWrCyc), 32'(lastRdCyc));
    check(rd == pat(16'hD5), "R6 new line data", rd, pat(16'hD5));
  endtask

  task automatic t_cleanEvict();
    logic [31:0] rd; int w; int r0;
    r0 = memReads;
    access(1'b0, 16'h0055, '0, rd, w);
    check(memWrites == 1, "R7 clean victim not written", 32'(memWrites), 32'h1);
    check(memReads == r0 + 1, "R7 single fill", 32'(memReads), 32'(r0 + 1));
    check(rd == 32'hDEAD_0001, "R7 refetched written word", rd, 32'hDEAD_0001);
  endtask

  task automatic t_writeMiss();
    logic [31:0] rd; int w; int wr0;
    access(1'b1, 16'h0200, 32'hCAFE_0002, rd, w);
    check(w > 0, "R10 write miss waits", 32'(w), 32'h1);
    access(1'b0, 16'h0200, '0, rd, w);
    check(w == 0 && rd == 32'hCAFE_0002, "R10 merged word", rd, 32'hCAFE_0002);
    access(1'b0, 16'h0201, '0, rd, w);
    check(rd == pat(16'h201), "R10 rest of line from memory", rd, pat(16'h201));
    wr0 = memWrites;
    access(1'b0, 16'h0280, '0, rd, w);
    check(memWrites == wr0 + 1 && lastWrAddr == 10'h200, "R10 line left dirty",
          32'(lastWrAddr), 32'h200);
  endtask

  task automatic t_resetClears();
    logic [31:0] rd; int w; int wr0;
    access(1'b1, 16'h0010, 32'hBEEF_0003, rd, w);
    doReset();
    wr0 = memWrites;
    access(1'b0, 16'h0010, '0, rd, w);
    check(w > 0, "R9 reset invalidates", 32'(w), 32'h1);
    check(memWrites == wr0, "R9 reset clears dirty", 32'(memWrites), 32'(wr0));
    check(rd == pat(16'h10), "R9 data from memory after reset", rd, pat(16'h10));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_hits();
    t_wrap();
    t_dirtyEvict();
    t_cleanEvict();
    t_writeMiss();
    t_resetClears();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule